// File: doc/BRIEF.md
# HDLC Receive Deframer with Status Byte

This block recovers frames from a serial HDLC bit stream. One line bit is presented per cycle when `bit_valid_i` is high. The block hunts for the 0x7E flag and removes the zero bits that the transmitter inserted after each run of five ones. It packs the surviving bits into bytes, least significant bit first, and writes each byte into a downstream receive FIFO through a plain write-enable/data pair. The FIFO, its host read side and the line clock recovery are not part of the block.

Frame status is not given on a side signal. Once a frame closes, the block writes one extra byte into the same stream, directly behind the two checksum bytes. That byte is 0x00 when the frame is valid. Otherwise it holds a nonzero code that names the fault: checksum error, bad length or alignment, or abort.

Flags and idle line produce no writes. A single flag can close one frame and open the next. A run of seven ones inside a frame aborts it, and the block then waits for a new flag.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A flag (bits 0,1,1,1,1,1,1,0 in line order), and any run of flags with no data bits between them, causes no write.
- R2: A zero received directly after five consecutive ones is discarded and never becomes data. The first data bit received after the opening flag becomes bit 0 of the first byte.
- R3: Every byte between the opening and closing flag is written exactly once, in arrival order, as a single-cycle `wr_en_o` pulse. This includes both checksum bytes.
- R4: The frame checksum is FCS-16: reflected polynomial 0x8408, preset 0xFFFF, sent complemented with the low byte first. A frame that meets all three conditions below gets exactly one status byte 0x00, written after its last data byte:
  - it has at least 4 bytes;
  - its bit count is a multiple of 8;
  - its register residue is 0xF0B8.
- R5: A frame of valid length and alignment whose residue is not 0xF0B8 gets the status byte 0x01.
- R6: A frame shorter than 4 bytes, or one whose bit count is not a multiple of 8, gets the status byte 0x02. This code takes priority over 0x01. The leftover partial bits are never written.
- R7: Seven or more consecutive ones inside a frame that already carried data end it with status byte 0x04 as its last write. Only whole bytes received before the abort may precede that status byte. All bits are then ignored until the next flag.
- R8: A single flag closes the current frame and also opens the next one.
- R9: `bit_i` is ignored in every cycle where `bit_valid_i` is low.
- R10: After reset the block writes nothing and hunts for a flag, so bits before the first flag are ignored. A flag followed only by idle ones writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_valid_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Received line bit |
| wr_en_o | output | 1 | FIFO write strobe, one byte per pulse |
| wr_data_o | output | 8 | Data or status byte |

## Verification
Four properties are checked on every cycle:
- a write is only ever caused by a qualified bit one or two cycles earlier;
- a pending status always reaches the write port on the next cycle;
- nothing is written while hunting with no status pending;
- an abort always leaves the frame state.

The bench also checks on every cycle that the lookahead buffer never holds a full window. Whether the bytes are the right ones, in the right order, and carry the right status code can only be shown by the bench's scenarios. These include stuffed payloads, shared flags, gapped bit strobes, corrupted checksums, short and misaligned frames, and aborts followed by garbage.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int RUN_LEN   = 5;                  // ones before a stuffed zero
  localparam int ASM_DEPTH = 8 + RUN_LEN + 1;    // byte plus worst-case flag lookahead
  localparam int ASM_CW    = $clog2(ASM_DEPTH + 1);

  localparam logic [7:0] ST_GOOD   = 8'h00;
  localparam logic [7:0] ST_FCS    = 8'h01;
  localparam logic [7:0] ST_FORMAT = 8'h02;
  localparam logic [7:0] ST_ABORT  = 8'h04;

  localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
  localparam logic [15:0] FCS_POLY    = 16'h8408;
  localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;

  function automatic logic [15:0] fcs_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ FCS_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_bit_filter.sv
module hdlc_bit_filter
  import hdlc_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic data_o,       // bit is payload
  output logic flag_o,       // closing zero of a flag
  output logic abort_o,      // seventh consecutive one
  output logic lead_zero_o   // zero before current ones run was payload
);
  localparam int OW = $clog2(RUN_LEN + 3);
  localparam logic [OW-1:0] RUN  = OW'(RUN_LEN);
  localparam logic [OW-1:0] FRUN = OW'(RUN_LEN + 1);
  localparam logic [OW-1:0] SAT  = OW'(RUN_LEN + 2);

  logic [OW-1:0] ones_q;
  logic          lz_q;

  always_comb begin
    data_o  = valid_i && (ones_q < RUN);
    flag_o  = valid_i && !bit_i && (ones_q == FRUN);
    abort_o = valid_i &&  bit_i && (ones_q == FRUN);
  end

  assign lead_zero_o = lz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      lz_q   <= 1'b0;
    end else if (valid_i) begin
      if (bit_i) begin
        if (ones_q != SAT) ones_q <= ones_q + 1'b1;
      end else begin
        ones_q <= '0;
        lz_q   <= (ones_q < RUN);
      end
    end
  end
endmodule

// File: rtl/hdlc_byte_assembler.sv
module hdlc_byte_assembler
  import hdlc_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              bit_i,
  input  logic              clear_i,
  output logic              byte_vld_o,
  output logic [7:0]        byte_o,
  output logic [7:0]        tail_o,
  output logic [ASM_CW-1:0] cnt_o
);
  localparam int BW = 2 ** ASM_CW;

  logic [BW-1:0]     sh_q, sh_n;
  logic [ASM_CW-1:0] cnt_q, cnt_n;

  // a byte leaves only once enough later bits prove it is not part of a flag
  always_comb begin
    sh_n       = sh_q;
    cnt_n      = cnt_q;
    byte_vld_o = 1'b0;
    if (push_i) begin
      sh_n[cnt_q] = bit_i;
      cnt_n       = cnt_q + 1'b1;
    end
    byte_o = sh_n[7:0];
    if (cnt_n == ASM_CW'(ASM_DEPTH)) begin
      byte_vld_o = 1'b1;
      sh_n       = sh_n >> 8;
      cnt_n      = cnt_n - ASM_CW'(8);
    end
    if (clear_i) begin
      sh_n  = '0;
      cnt_n = '0;
    end
  end

  assign tail_o = sh_q[7:0];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16
  import hdlc_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= FCS_PRESET;
    else if (init_i) crc_o <= FCS_PRESET;
    else if (upd_i)  crc_o <= fcs_byte(crc_o, byte_i);
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_FRAME_BYTES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_valid_i,
  input  logic       bit_i,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o
);
  localparam int NBW = $clog2(MIN_FRAME_BYTES + 1);

  logic              ev_data, ev_flag, ev_abort, lead_zero;
  logic              in_frame_q, stat_pend_q, stat_chk_q;
  logic [7:0]        stat_code_q;
  logic [NBW-1:0]    nbytes_q;
  logic              byte_vld;
  logic [7:0]        byte_d, tail;
  logic [ASM_CW-1:0] asm_cnt;
  logic [15:0]       crc;
  logic [ASM_CW:0]   rem;
  logic              has_data, close, kill, tail_wr, short_frm, misalign;
  logic              fcs_init, fcs_upd;
  logic [7:0]        fcs_in, status;

  hdlc_bit_filter i_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (bit_valid_i),
    .bit_i      (bit_i),
    .data_o     (ev_data),
    .flag_o     (ev_flag),
    .abort_o    (ev_abort),
    .lead_zero_o(lead_zero)
  );

  hdlc_byte_assembler i_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ev_data & in_frame_q),
    .bit_i     (bit_i),
    .clear_i   (ev_flag | ev_abort),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_d),
    .tail_o    (tail),
    .cnt_o     (asm_cnt)
  );

  hdlc_fcs16 i_fcs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(fcs_init),
    .upd_i (fcs_upd),
    .byte_i(fcs_in),
    .crc_o (crc)
  );

  // bits still buffered once the flag's own leading bits are removed
  always_comb begin
    rem       = {1'b0, asm_cnt} - (ASM_CW + 1)'(RUN_LEN) - (ASM_CW + 1)'(lead_zero);
    has_data  = (nbytes_q != '0) || (rem != '0);
    close     = ev_flag  && in_frame_q && has_data;
    kill      = ev_abort && in_frame_q && has_data;
    tail_wr   = close && (rem == (ASM_CW + 1)'(8));
    misalign  = (rem != '0) && (rem != (ASM_CW + 1)'(8));
    short_frm = ({1'b0, nbytes_q} + (NBW + 1)'(tail_wr)) < (NBW + 1)'(MIN_FRAME_BYTES);
    fcs_init  = stat_pend_q || (ev_flag && !close) || ev_abort;
    fcs_upd   = byte_vld || tail_wr;
    fcs_in    = tail_wr ? tail : byte_d;
    status    = stat_chk_q ? ((crc == FCS_RESIDUE) ? ST_GOOD : ST_FCS) : stat_code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q  <= 1'b0;
      nbytes_q    <= '0;
      stat_pend_q <= 1'b0;
      stat_chk_q  <= 1'b0;
      stat_code_q <= ST_GOOD;
      wr_en_o     <= 1'b0;
      wr_data_o   <= '0;
    end else begin
      if (ev_flag)       in_frame_q <= 1'b1;
      else if (ev_abort) in_frame_q <= 1'b0;

      if (ev_flag || ev_abort) nbytes_q <= '0;
      else if (byte_vld && nbytes_q != NBW'(MIN_FRAME_BYTES)) nbytes_q <= nbytes_q + 1'b1;

      stat_pend_q <= close || kill;
      stat_chk_q  <= close && !kill && !short_frm && !misalign;
      stat_code_q <= kill ? ST_ABORT : ST_FORMAT;

      wr_en_o   <= byte_vld || tail_wr || stat_pend_q;
      wr_data_o <= stat_pend_q ? status : fcs_in;
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
  import hdlc_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_valid_i,
  input logic              wr_en_o,
  input logic              in_frame_q,
  input logic              stat_pend_q,
  input logic              ev_abort,
  input logic [ASM_CW-1:0] asm_cnt
);
  // R9: a write always traces back to a qualified bit
  a_r9_write_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ($past(bit_valid_i) || $past(bit_valid_i, 2)));

  // R4: a decided status reaches the FIFO on the next cycle
  a_r4_status_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_pend_q |=> wr_en_o);

  // R10: hunting with nothing pending is silent
  a_r10_hunt_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_q && !stat_pend_q) |=> !wr_en_o);

  // R7: an abort drops back to hunting
  a_r7_abort_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_abort |=> !in_frame_q);

  // R3: bytes drain before the lookahead window overflows
  a_r3_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asm_cnt < ASM_CW'(ASM_DEPTH));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_valid_i(bit_valid_i),
  .wr_en_o    (wr_en_o),
  .in_frame_q (in_frame_q),
  .stat_pend_q(stat_pend_q),
  .ev_abort   (ev_abort),
  .asm_cnt    (asm_cnt)
);

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_rx_deframer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic       din = 1'b0;
  logic       wr_en;
  logic [7:0] wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit gaps_on = 1'b0;
  int tx_ones = 0;

  logic [7:0] pl[$];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  always #4 clk = ~clk;

  hdlc_rx_deframer i_hdlc_rx_deframer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bit_valid_i(vld),
    .bit_i      (din),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data)
  );

  always @(negedge clk) if (rst_n && wr_en) got_q.push_back(wr_data);

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    if (gaps_on && ($urandom % 4 == 0)) begin
      @(negedge clk); vld = 1'b0; din = 1'($urandom);
    end
    @(negedge clk); vld = 1'b1; din = b;
  endtask

  task automatic send_data_bit(input logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) send_data_bit(d[i]);
  endtask

  task automatic send_flag();
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) send_bit(f[i]);
    tx_ones = 0;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  function automatic logic [15:0] ref_fcs();
    logic [15:0] c = 16'hFFFF;
    foreach (pl[i]) for (int j = 0; j < 8; j++) begin
      logic fb = c[0] ^ pl[i][j];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic logic [7:0] exp_status(input int nbytes, input int extra, input bit bad);
    if ((extra % 8) != 0 || nbytes < 4) return 8'h02;
    return bad ? 8'h01 : 8'h00;
  endfunction

  task automatic fill(input int n);
    pl.delete();
    for (int i = 0; i < n; i++) pl.push_back(8'($urandom));
  endtask

  // payload, FCS, extra bits, closing flag; opening flag sent by caller
  task automatic send_frame(input bit bad, input int extra);
    logic [15:0] c;
    c = ~ref_fcs();
    if (bad) c = c ^ 16'h0100;
    foreach (pl[i]) begin send_byte(pl[i]); exp_q.push_back(pl[i]); end
    send_byte(c[7:0]);  exp_q.push_back(c[7:0]);
    send_byte(c[15:8]); exp_q.push_back(c[15:8]);
    for (int i = 0; i < extra; i++) send_data_bit(1'($urandom));
    send_flag();
    exp_q.push_back(exp_status(pl.size() + 2, extra, bad));
  endtask

  task automatic cmp_stream(input string tag);
    int n;
    send_ones(12);
    @(negedge clk); vld = 1'b0;
    repeat (40) @(negedge clk);
    check(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    void'($urandom(32'h1D0F));
    repeat (5) @(negedge clk);
    check(wr_en == 1'b0, "R10 reset", wr_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(wr_en == 1'b0, "R10 after reset", wr_en, 0);

    // R10: bits before any flag ignored
    for (int i = 0; i < 24; i++) send_bit(1'(i % 2));
    send_ones(10);
    cmp_stream("R10 pre-flag bits");

    // R1: flags only, then idle ones
    repeat (4) send_flag();
    cmp_stream("R1 flags only");

    // R2 R3 R4: directed stuffing-heavy frame
    send_flag();
    pl.delete();
    pl.push_back(8'hFF); pl.push_back(8'h7E); pl.push_back(8'h3F);
    pl.push_back(8'hF8); pl.push_back(8'h01);
    send_frame(1'b0, 0);
    cmp_stream("R2,R3,R4 stuffed frame");

    // R8 R9: shared flags, gapped strobe
    gaps_on = 1'b1;
    send_flag();
    for (int k = 0; k < 25; k++) begin
      fill(2 + int'($urandom % 15));
      send_frame(1'b0, 0);
    end
    cmp_stream("R8,R9 shared flags");

    // R5: corrupted checksum
    send_flag();
    fill(6);
    send_frame(1'b1, 0);
    cmp_stream("R5 bad fcs");

    // R6: too short, minimum length, misaligned
    send_flag();
    fill(1); send_frame(1'b0, 0);
    fill(2); send_frame(1'b0, 0);
    fill(4); send_frame(1'b0, 3);
    fill(3); send_frame(1'b1, 5);
    cmp_stream("R6 length/alignment");

    // R7: abort, then garbage while hunting, then a good frame
    send_flag();
    fill(4); pl.push_back(8'h00);
    foreach (pl[i]) send_byte(pl[i]);
    send_ones(15);
    @(negedge clk); vld = 1'b0;
    repeat (20) @(negedge clk);
    check(got_q.size() >= 1 && got_q.size() <= pl.size() + 1, "R7 abort count", got_q.size(), pl.size());
    if (got_q.size() >= 1) begin
      check(got_q[got_q.size() - 1] == 8'h04, "R7 abort code", got_q[got_q.size() - 1], 8'h04);
      for (int i = 0; i < got_q.size() - 1; i++) check(got_q[i] == pl[i], "R7 abort prefix", got_q[i], pl[i]);
    end
    got_q.delete();
    tx_ones = 0;
    for (int i = 0; i < 4; i++) send_byte(8'($urandom));
    send_flag();
    fill(5);
    send_frame(1'b0, 0);
    cmp_stream("R7 hunt after abort");

    // mixed random frames
    send_flag();
    for (int k = 0; k < 30; k++) begin
      int kind = int'($urandom % 4);
      fill((kind == 2) ? 1 : 2 + int'($urandom % 12));
      send_frame(kind == 1, (kind == 3) ? 1 + int'($urandom % 7) : 0);
    end
    cmp_stream("R4,R5,R6 mixed");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule